// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block controls three 16-pin general-purpose I/O ports. Each port is set up through four registers: a data buffer, a direction word, an attribute word and a special-function mask. Together they decide, for every pin, whether it drives or listens, the polarity of the driven level, and whether a pull resistor is applied. A masked pin gives up its own logic to an alternate-function source. A global configuration register chooses between two alternate-function sources for the first two ports and enables wakeup requests for each port.

Software reads a port's data buffer at one address and the synchronized pin levels at another. The pad inputs pass through a two-flop synchronizer. When any synchronized bit of a wakeup-enabled port changes, the block raises a wakeup request for one cycle. Pad analog details and the alternate functions themselves are outside the block. They appear only as input and output vectors.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0. All pins are then inputs (pad_oe = 0) with the pull-down enabled (pad_pd all ones, pad_pu all zeros), and wake_req is 0.
- R2: On an unmasked pin, direction bit 1 sets pad_oe to 1 and direction bit 0 clears it.
- R3: On an unmasked pin, pad_out equals the data bit when the attribute bit is 1, and equals the inverted data bit when the attribute bit is 0.
- R4: An unmasked input pin with attribute 0 enables the pull-up when its data bit is 1 and the pull-down when its data bit is 0. The two pulls are never on together.
- R5: An input pin with attribute 1 has no pull enabled. An output pin has no pull enabled.
- R6: A pin whose mask bit is 1 takes pad_out and pad_oe from alternate source 0 or 1, and has no pull enabled. Config bit 0 selects the source for port 0 and config bit 1 for port 1 (0 = source 0, 1 = source 1). Port 2 always uses source 0.
- R7: Address = port*8 + offset. Offsets 0, 2, 3 and 4 read back data, direction, attribute and mask. Offset 1 reads the pin levels, which become visible two clock edges after a pad changes.
- R8: Address 24 holds the 5-bit configuration. A write stores bits 4:0 and ignores the rest, and a read returns them zero-extended.
- R9: Config bit 2+p enables wakeup for port p. wake_req is 1 for exactly one cycle, two edges after a pad of an enabled port changes. A change on a disabled port never raises it.
- R10: A write to a port's pin-level offset (offset 1) changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 5 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| pad_in | input | 48 | Pad levels, port p at bits 16p+15:16p |
| pad_out | output | 48 | Driven pad levels |
| pad_oe | output | 48 | Pad output enables |
| pad_pu | output | 48 | Pull-up enables |
| pad_pd | output | 48 | Pull-down enables |
| alt0_out | input | 48 | Alternate source 0 output levels |
| alt0_oe | input | 48 | Alternate source 0 output enables |
| alt1_out | input | 48 | Alternate source 1 output levels |
| alt1_oe | input | 48 | Alternate source 1 output enables |
| alt_in | output | 48 | Synchronized pad levels offered to alternate functions |
| wake_req | output | 1 | One-cycle wakeup request |

## Verification
The hardest situation to reach is a pad change on a port whose wakeup is disabled, while another port is enabled. The wake output must stay silent across the whole two-edge synchronizer window. The bench enables only port 1. It then toggles a port-0 pad and samples wake_req after each of the next three edges. Next it toggles a port-1 pad and confirms that the pulse appears only after the second edge and is gone after the third. The mixed-mask case is reached by masking only the low nibble of a port that still has unmasked pull-configured inputs. This checks the alternate and the own pin logic side by side within one port.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PIN_W = 16;

    typedef logic [PIN_W-1:0] pins_t;

    typedef enum logic [2:0] {
        OFS_DATA  = 3'd0,
        OFS_LEVEL = 3'd1,
        OFS_DIR   = 3'd2,
        OFS_ATTR  = 3'd3,
        OFS_MASK  = 3'd4
    } ofs_e;

    typedef struct packed {
        pins_t data;
        pins_t dir;
        pins_t attr;
        pins_t mask;
    } port_regs_t;

    typedef struct packed {
        pins_t out;
        pins_t oe;
        pins_t pu;
        pins_t pd;
    } pad_drv_t;

    // Pin drive from register state and the chosen alternate source.
    function automatic pad_drv_t drive_pins(port_regs_t r, pins_t sf_out, pins_t sf_oe);
        pad_drv_t d;
        pins_t own_out;
        pins_t pull_en;
        own_out = ~(r.attr ^ r.data);          // attr 1: pass, attr 0: invert
        pull_en = ~r.mask & ~r.dir & ~r.attr;
        d.out   = (r.mask & sf_out) | (~r.mask & own_out);
        d.oe    = (r.mask & sf_oe)  | (~r.mask & r.dir);
        d.pu    = pull_en & r.data;
        d.pd    = pull_en & ~r.data;
        return d;
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] level_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] meta_q;
    logic [W-1:0] level_q;
    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q  <= '0;
            level_q <= '0;
            prev_q  <= '0;
        end else begin
            meta_q  <= pin_i;
            level_q <= meta_q;
            prev_q  <= level_q;
        end
    end

    assign level_o = level_q;
    assign prev_o  = prev_q;

    // Cycle counter so the latency check looks back only over post-reset cycles.
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst)              age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assert_sync_latency_R7: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2) |-> (level_o == $past(pin_i, 2)));

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_i,
    input  logic       sel_i,
    input  logic [2:0] ofs_i,
    input  pins_t      wdata_i,
    input  logic       alt_sel_i,
    input  pins_t      alt0_out_i,
    input  pins_t      alt0_oe_i,
    input  pins_t      alt1_out_i,
    input  pins_t      alt1_oe_i,
    output port_regs_t regs_o,
    output pad_drv_t   drv_o
);
    port_regs_t regs_q;
    pins_t      sf_out;
    pins_t      sf_oe;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_i && sel_i) begin
            case (ofs_i)
                OFS_DATA: regs_q.data <= wdata_i;
                OFS_DIR:  regs_q.dir  <= wdata_i;
                OFS_ATTR: regs_q.attr <= wdata_i;
                OFS_MASK: regs_q.mask <= wdata_i;
                default:  ;                      // pin-level offset is read-only
            endcase
        end
    end

    always_comb begin
        sf_out = alt_sel_i ? alt1_out_i : alt0_out_i;
        sf_oe  = alt_sel_i ? alt1_oe_i  : alt0_oe_i;
        drv_o  = drive_pins(regs_q, sf_out, sf_oe);
    end

    assign regs_o = regs_q;

    assert_dir_write_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel_i && ofs_i == OFS_DIR) |=>
            ((drv_o.oe & ~regs_q.mask) == ($past(wdata_i) & ~regs_q.mask)));

    assert_pulls_exclusive_R4: assert property (@(posedge clk) disable iff (rst)
        (drv_o.pu & drv_o.pd) == '0);

    assert_level_write_ignored_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_i && sel_i && ofs_i == OFS_LEVEL) |=> (regs_q == $past(regs_q)));

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int NUM_PORTS = 3,
    parameter int SEL_PORTS = 2,
    localparam int IDX_W    = $clog2(NUM_PORTS + 1),
    localparam int ADDR_W   = IDX_W + 3,
    localparam int BUS_W    = NUM_PORTS * PIN_W,
    localparam int CFG_W    = SEL_PORTS + NUM_PORTS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PIN_W-1:0]  bus_wdata,
    output logic [PIN_W-1:0]  bus_rdata,
    input  logic [BUS_W-1:0]  pad_in,
    output logic [BUS_W-1:0]  pad_out,
    output logic [BUS_W-1:0]  pad_oe,
    output logic [BUS_W-1:0]  pad_pu,
    output logic [BUS_W-1:0]  pad_pd,
    input  logic [BUS_W-1:0]  alt0_out,
    input  logic [BUS_W-1:0]  alt0_oe,
    input  logic [BUS_W-1:0]  alt1_out,
    input  logic [BUS_W-1:0]  alt1_oe,
    output logic [BUS_W-1:0]  alt_in,
    output logic              wake_req
);
    localparam logic [IDX_W-1:0] CFG_SLOT = IDX_W'(NUM_PORTS);

    logic [IDX_W-1:0]     slot;
    logic [2:0]           ofs;
    logic [CFG_W-1:0]     cfg_q;
    logic [BUS_W-1:0]     level;
    logic [BUS_W-1:0]     prev;
    logic [NUM_PORTS-1:0] alt_sel;
    logic [NUM_PORTS-1:0] port_moved;
    port_regs_t           regs [NUM_PORTS];
    pad_drv_t             drv  [NUM_PORTS];

    assign slot = bus_addr[ADDR_W-1:3];
    assign ofs  = bus_addr[2:0];

    always_ff @(posedge clk) begin
        if (rst)
            cfg_q <= '0;
        else if (bus_wr && slot == CFG_SLOT && ofs == 3'd0)
            cfg_q <= bus_wdata[CFG_W-1:0];
    end

    gpio_sync #(.W(BUS_W)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .pin_i   (pad_in),
        .level_o (level),
        .prev_o  (prev)
    );

    assign alt_in = level;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        if (p < SEL_PORTS) begin : g_sel
            assign alt_sel[p] = cfg_q[p];
        end else begin : g_fixed
            assign alt_sel[p] = 1'b0;
        end

        gpio_port_bank u_bank (
            .clk        (clk),
            .rst        (rst),
            .wr_i       (bus_wr),
            .sel_i      (slot == IDX_W'(p)),
            .ofs_i      (ofs),
            .wdata_i    (bus_wdata),
            .alt_sel_i  (alt_sel[p]),
            .alt0_out_i (alt0_out[p*PIN_W +: PIN_W]),
            .alt0_oe_i  (alt0_oe[p*PIN_W +: PIN_W]),
            .alt1_out_i (alt1_out[p*PIN_W +: PIN_W]),
            .alt1_oe_i  (alt1_oe[p*PIN_W +: PIN_W]),
            .regs_o     (regs[p]),
            .drv_o      (drv[p])
        );

        assign pad_out[p*PIN_W +: PIN_W] = drv[p].out;
        assign pad_oe [p*PIN_W +: PIN_W] = drv[p].oe;
        assign pad_pu [p*PIN_W +: PIN_W] = drv[p].pu;
        assign pad_pd [p*PIN_W +: PIN_W] = drv[p].pd;

        assign port_moved[p] = cfg_q[SEL_PORTS + p] &&
                               (level[p*PIN_W +: PIN_W] != prev[p*PIN_W +: PIN_W]);
    end

    assign wake_req = |port_moved;

    always_comb begin
        bus_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (slot == IDX_W'(p)) begin
                case (ofs)
                    OFS_DATA:  bus_rdata = regs[p].data;
                    OFS_LEVEL: bus_rdata = level[p*PIN_W +: PIN_W];
                    OFS_DIR:   bus_rdata = regs[p].dir;
                    OFS_ATTR:  bus_rdata = regs[p].attr;
                    OFS_MASK:  bus_rdata = regs[p].mask;
                    default:   bus_rdata = '0;
                endcase
            end
        end
        if (slot == CFG_SLOT && ofs == 3'd0)
            bus_rdata = PIN_W'(cfg_q);
    end

    assert_cfg_write_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && slot == CFG_SLOT && ofs == 3'd0) |=>
            (cfg_q == $past(bus_wdata[CFG_W-1:0])));

    assert_wake_needs_enable_R9: assert property (@(posedge clk) disable iff (rst)
        wake_req |-> (cfg_q[CFG_W-1:SEL_PORTS] != '0));

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (wake_req == 1'b0 && pad_oe == '0));

endmodule

// File: tb/gpio_port_ctrl_tb.sv
module gpio_port_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [47:0] pad_in = '0;
    logic [47:0] pad_out, pad_oe, pad_pu, pad_pd, alt_in;
    logic [47:0] alt0_out = {3{16'h1234}};
    logic [47:0] alt0_oe  = {3{16'h00FF}};
    logic [47:0] alt1_out = {3{16'hABCD}};
    logic [47:0] alt1_oe  = {3{16'hFF00}};
    logic        wake_req;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio_port_ctrl u_dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu), .pad_pd(pad_pd),
        .alt0_out(alt0_out), .alt0_oe(alt0_oe), .alt1_out(alt1_out),
        .alt1_oe(alt1_oe), .alt_in(alt_in), .wake_req(wake_req)
    );

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
        bus_addr = a;
        #0.5;
        chk(req, {32'b0, bus_rdata}, {32'b0, exp});
    endtask

    task automatic t_reset;
        @(negedge clk);
        for (int a = 0; a < 5; a++) rd_chk("R1 port0 reg", 5'(a), 16'h0000);
        rd_chk("R1 cfg", 5'd24, 16'h0000);
        chk("R1 oe", pad_oe, 48'h0);
        chk("R1 pd", pad_pd, {48{1'b1}});
        chk("R1 pu", pad_pu, 48'h0);
        chk("R1 wake", {47'b0, wake_req}, 48'h0);
    endtask

    task automatic t_output;
        wr(5'd2, 16'hFFFF);
        wr(5'd3, 16'h00FF);
        wr(5'd0, 16'h0F0F);
        chk("R2 port0 oe", {32'b0, pad_oe[15:0]}, 48'hFFFF);
        chk("R3 port0 polarity", {32'b0, pad_out[15:0]}, 48'hF00F);
        chk("R5 output no pu", {32'b0, pad_pu[15:0]}, 48'h0);
        chk("R5 output no pd", {32'b0, pad_pd[15:0]}, 48'h0);
        wr(5'd18, 16'h00F0);
        chk("R2 port2 partial oe", {32'b0, pad_oe[47:32]}, 48'h00F0);
        wr(5'd18, 16'h0000);
    endtask

    task automatic t_input_pull;
        wr(5'd11, 16'hF000);
        wr(5'd8, 16'h00FF);
        chk("R4 port1 pu", {32'b0, pad_pu[31:16]}, 48'h00FF);
        chk("R4 port1 pd", {32'b0, pad_pd[31:16]}, 48'h0F00);
        chk("R5 attr1 float", {32'b0, (pad_pu[31:28] | pad_pd[31:28])}, 48'h0);
        chk("R2 port1 input oe", {32'b0, pad_oe[31:16]}, 48'h0);
    endtask

    task automatic t_special;
        wr(5'd4, 16'hFFFF);
        wr(5'd24, 16'h0000);
        chk("R6 port0 src0 out", {32'b0, pad_out[15:0]}, 48'h1234);
        chk("R6 port0 src0 oe", {32'b0, pad_oe[15:0]}, 48'h00FF);
        wr(5'd24, 16'h0001);
        chk("R6 port0 src1 out", {32'b0, pad_out[15:0]}, 48'hABCD);
        chk("R6 port0 src1 oe", {32'b0, pad_oe[15:0]}, 48'hFF00);
        wr(5'd20, 16'hFFFF);
        wr(5'd24, 16'h0003);
        chk("R6 port2 fixed src0", {32'b0, pad_out[47:32]}, 48'h1234);
        chk("R6 port2 no pull", {32'b0, (pad_pu[47:32] | pad_pd[47:32])}, 48'h0);
        wr(5'd12, 16'h000F);
        wr(5'd24, 16'h0002);
        chk("R6 port1 mixed out", {32'b0, pad_out[31:16]}, 48'h0F0D);
        chk("R6 port1 mixed oe", {32'b0, pad_oe[31:16]}, 48'h0000);
        chk("R6 port1 mixed pu", {32'b0, pad_pu[31:16]}, 48'h00F0);
        chk("R6 port1 mixed pd", {32'b0, pad_pd[31:16]}, 48'h0F00);
        wr(5'd4, 16'h0000);
        wr(5'd12, 16'h0000);
        wr(5'd20, 16'h0000);
        wr(5'd24, 16'h0000);
    endtask

    task automatic t_readback;
        @(negedge clk);
        rd_chk("R7 dir", 5'd2, 16'hFFFF);
        rd_chk("R7 attr", 5'd3, 16'h00FF);
        rd_chk("R7 mask", 5'd4, 16'h0000);
        rd_chk("R7 data", 5'd8, 16'h00FF);
        pad_in[31:16] = 16'h3C3C;
        @(posedge clk); #0.5;
        rd_chk("R7 level after one edge", 5'd9, 16'h0000);
        @(posedge clk); #0.5;
        rd_chk("R7 level after two edges", 5'd9, 16'h3C3C);
    endtask

    task automatic t_ignore;
        @(negedge clk);
        pad_in[15:0] = 16'h5A5A;
        repeat (3) @(negedge clk);
        wr(5'd1, 16'hFFFF);
        rd_chk("R10 data untouched", 5'd0, 16'h0F0F);
        rd_chk("R10 level still pad", 5'd1, 16'h5A5A);
        rd_chk("R10 dir untouched", 5'd2, 16'hFFFF);
        wr(5'd24, 16'hFFFF);
        rd_chk("R8 cfg 5 bits", 5'd24, 16'h001F);
        wr(5'd24, 16'h0000);
        rd_chk("R8 cfg cleared", 5'd24, 16'h0000);
    endtask

    task automatic t_wake;
        wr(5'd24, 16'h0008);
        repeat (3) @(negedge clk);
        pad_in[0] = ~pad_in[0];
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #0.5;
            chk("R9 disabled port silent", {47'b0, wake_req}, 48'h0);
        end
        @(negedge clk);
        pad_in[20] = ~pad_in[20];
        @(posedge clk); #0.5;
        chk("R9 no pulse after one edge", {47'b0, wake_req}, 48'h0);
        @(posedge clk); #0.5;
        chk("R9 pulse after two edges", {47'b0, wake_req}, 48'h1);
        @(posedge clk); #0.5;
        chk("R9 pulse one cycle", {47'b0, wake_req}, 48'h0);
        wr(5'd24, 16'h0000);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset;
        t_output;
        t_input_pull;
        t_special;
        t_readback;
        t_ignore;
        t_wake;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule